// File: doc/BRIEF.md
# Bounded Loop and Index Counter Unit

This unit steers the program counter for a fixed-trip loop instruction and forms effective addresses for loop-relative loads and stores. It keeps two separate banks of counters: eight loop-count registers, which count the remaining iterations of a count-and-jump loop, and eight index counters, which supply offsets that are added to an immediate to form an address. All counter values come from immediates only. No branch target and no address ever depends on data computed at run time.

The unit receives decoded operation strobes for count-jump, index-init and index-increment. With them come a current program counter, a loop start address, an iteration count, an immediate value and two counter selects. It returns the next program counter and the effective address as combinational outputs. The counter updates take place on the following clock edge. None of the strobes is gated by a predicate, so each one takes effect whenever it is asserted.

A trip count of N makes the loop body run N times. The body runs once before the first count-jump is reached. That first count-jump stores N-1 and jumps back, and each later count-jump either decrements the stored value and jumps or leaves the loop. Counts of 0 and 1 leave the loop at once.

Top module: `loop_index_unit`

## Requirements
- R1: After reset all index counters hold 0 and all loop counters are unarmed.
- R2: When count-jump is low, nextPc equals pcIn + 1, modulo 2^16.
- R3: A count-jump on an unarmed loop counter with loopCount of 2 or more arms that counter, stores loopCount - 1 and drives nextPc to targetAddr.
- R4: A count-jump on an armed counter whose stored value is greater than 1 decrements the stored value by 1 and drives nextPc to targetAddr.
- R5: A count-jump on an armed counter whose stored value is 1 drives nextPc to pcIn + 1 and disarms the counter. A loop with trip count N therefore jumps back exactly N-1 times.
- R6: A count-jump on an unarmed counter with loopCount of 0 or 1 drives nextPc to pcIn + 1 and leaves the counter unarmed.
- R7: After a loop exits, a later count-jump on the same counter loads the new loopCount afresh.
- R8: A count-jump changes only the loop counter chosen by loopSel. Cycles without count-jump change no loop counter.
- R9: Index-init writes immVal into the index counter chosen by idxSel.
- R10: Index-increment adds immVal to the chosen index counter, modulo 2^16.
- R11: When index-init and index-increment are asserted in the same cycle, the init takes effect and the increment is ignored.
- R12: effAddr equals immVal plus the current value of the index counter chosen by idxSel, modulo 2^16. The value is the one held before this cycle's update.
- R13: A count-jump and an index operation in the same cycle both take full effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cjEn | input | 1 | Count-jump strobe |
| initEn | input | 1 | Index-init strobe |
| incEn | input | 1 | Index-increment strobe |
| loopSel | input | 3 | Loop counter select |
| idxSel | input | 3 | Index counter select |
| loopCount | input | 16 | Iteration count immediate for count-jump |
| immVal | input | 16 | Immediate for address base, init value or increment step |
| pcIn | input | 16 | Current program counter |
| targetAddr | input | 16 | Loop start address |
| nextPc | output | 16 | Next program counter |
| effAddr | output | 16 | Effective address, immVal plus selected index counter |

## Verification
A count-jump on one loop counter can fall in the same cycle as an index-init or index-increment on an index counter. Init and increment can also both be asserted on the same index counter. The bench provokes both cases. It issues an increment while a loop iterates, and it issues combined init and increment strobes. It then judges the result through nextPc and through effAddr in the following cycle. Both banks must show their update, and for the combined strobes only the init value may appear.

// File: rtl/lbx_pkg.sv
`timescale 1ns/1ps
package lbx_pkg;
  typedef struct packed {
    logic takeJump;
    logic writeLoop;
    logic setArmed;
    logic clrArmed;
    logic writeIdx;
    logic addIdx;
  } lbx_ctrl_t;
endpackage

// File: rtl/lbx_control.sv
`timescale 1ns/1ps
module lbx_control
  import lbx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             cjEn,
  input  logic             initEn,
  input  logic             incEn,
  input  logic             selArmed,
  input  logic [CNT_W-1:0] selCnt,
  input  logic [CNT_W-1:0] loopCount,
  output lbx_ctrl_t        ctrl,
  output logic [CNT_W-1:0] newCnt
);
  logic [CNT_W-1:0] effCnt;
  logic             moreLeft;

  always_comb begin
    effCnt   = selArmed ? selCnt : loopCount;
    moreLeft = effCnt > CNT_W'(1);
    newCnt   = effCnt - CNT_W'(1);
    ctrl     = '0;
    if (cjEn) begin
      if (moreLeft) begin
        ctrl.takeJump  = 1'b1;
        ctrl.writeLoop = 1'b1;
        ctrl.setArmed  = 1'b1;
      end else begin
        ctrl.clrArmed  = 1'b1;
      end
    end
    ctrl.writeIdx = initEn;
    ctrl.addIdx   = incEn & ~initEn;
  end
endmodule

// File: rtl/lbx_datapath.sv
`timescale 1ns/1ps
module lbx_datapath
  import lbx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int NUM_LOOP = 8,
  parameter int NUM_IDX  = 8,
  localparam int LSEL_W  = $clog2(NUM_LOOP),
  localparam int ISEL_W  = $clog2(NUM_IDX)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  lbx_ctrl_t                      ctrl,
  input  logic [CNT_W-1:0]               newCnt,
  input  logic [LSEL_W-1:0]              loopSel,
  input  logic [ISEL_W-1:0]              idxSel,
  input  logic [ADDR_W-1:0]              immVal,
  input  logic [ADDR_W-1:0]              pcIn,
  input  logic [ADDR_W-1:0]              targetAddr,
  output logic                           selArmed,
  output logic [CNT_W-1:0]               selCnt,
  output logic [ADDR_W-1:0]              nextPc,
  output logic [ADDR_W-1:0]              effAddr
);
  logic [NUM_LOOP-1:0]             armedVec;
  logic [NUM_LOOP-1:0][CNT_W-1:0]  loopBank;
  logic [NUM_IDX-1:0][ADDR_W-1:0]  idxBank;

  assign selArmed = armedVec[loopSel];
  assign selCnt   = loopBank[loopSel];
  assign nextPc   = ctrl.takeJump ? targetAddr : pcIn + ADDR_W'(1);
  assign effAddr  = immVal + idxBank[idxSel];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LOOP; gi++) begin : g_loop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          armedVec[gi] <= 1'b0;
          loopBank[gi] <= '0;
        end else if (loopSel == LSEL_W'(gi)) begin
          if (ctrl.writeLoop) loopBank[gi] <= newCnt;
          if (ctrl.setArmed) armedVec[gi] <= 1'b1;
          else if (ctrl.clrArmed) armedVec[gi] <= 1'b0;
        end
      end
    end
    for (gi = 0; gi < NUM_IDX; gi++) begin : g_idx
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          idxBank[gi] <= '0;
        end else if (idxSel == ISEL_W'(gi)) begin
          if (ctrl.writeIdx) idxBank[gi] <= immVal;
          else if (ctrl.addIdx) idxBank[gi] <= idxBank[gi] + immVal;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/loop_index_unit.sv
`timescale 1ns/1ps
module loop_index_unit
  import lbx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int NUM_LOOP = 8,
  parameter int NUM_IDX  = 8,
  localparam int LSEL_W  = $clog2(NUM_LOOP),
  localparam int ISEL_W  = $clog2(NUM_IDX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cjEn,
  input  logic              initEn,
  input  logic              incEn,
  input  logic [LSEL_W-1:0] loopSel,
  input  logic [ISEL_W-1:0] idxSel,
  input  logic [CNT_W-1:0]  loopCount,
  input  logic [ADDR_W-1:0] immVal,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] effAddr
);
  lbx_ctrl_t        ctrl;
  logic [CNT_W-1:0] newCnt;
  logic             selArmed;
  logic [CNT_W-1:0] selCnt;

  lbx_control #(.CNT_W(CNT_W)) u_ctl (
    .cjEn(cjEn), .initEn(initEn), .incEn(incEn),
    .selArmed(selArmed), .selCnt(selCnt), .loopCount(loopCount),
    .ctrl(ctrl), .newCnt(newCnt)
  );

  lbx_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LOOP(NUM_LOOP), .NUM_IDX(NUM_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .newCnt(newCnt),
    .loopSel(loopSel), .idxSel(idxSel), .immVal(immVal), .pcIn(pcIn),
    .targetAddr(targetAddr), .selArmed(selArmed), .selCnt(selCnt),
    .nextPc(nextPc), .effAddr(effAddr)
  );
endmodule

// File: rtl/lbx_chk.sv
`timescale 1ns/1ps
module lbx_chk
  import lbx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int NUM_LOOP = 8,
  parameter int NUM_IDX  = 8,
  localparam int LSEL_W  = $clog2(NUM_LOOP),
  localparam int ISEL_W  = $clog2(NUM_IDX)
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cjEn,
  input logic                          initEn,
  input logic                          incEn,
  input logic [LSEL_W-1:0]             loopSel,
  input logic [ISEL_W-1:0]             idxSel,
  input logic [ADDR_W-1:0]             immVal,
  input logic [ADDR_W-1:0]             pcIn,
  input logic [ADDR_W-1:0]             targetAddr,
  input logic [ADDR_W-1:0]             nextPc,
  input lbx_ctrl_t                     ctrl,
  input logic [NUM_LOOP-1:0]           armedVec,
  input logic [NUM_LOOP-1:0][CNT_W-1:0] loopBank,
  input logic [NUM_IDX-1:0][ADDR_W-1:0] idxBank
);
  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cjEn |-> nextPc == ADDR_W'(pcIn + ADDR_W'(1)));

  // R3
  jump_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cjEn && ctrl.takeJump) |-> nextPc == targetAddr);

  // R4
  jump_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cjEn && ctrl.takeJump) |=> armedVec[$past(loopSel)]);

  // R5
  exit_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cjEn && !ctrl.takeJump) |=> !armedVec[$past(loopSel)]);

  // R8
  idle_loop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cjEn |=> ($stable(armedVec) && $stable(loopBank)));

  // R9
  init_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    initEn |=> idxBank[$past(idxSel)] == $past(immVal));

  // R10
  inc_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !initEn) |=> idxBank[$past(idxSel)] == ADDR_W'($past(idxBank[idxSel]) + $past(immVal)));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LOOP; gi++) begin : g_nz
      // R5
      armed_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
        armedVec[gi] |-> loopBank[gi] != '0);
    end
  endgenerate
endmodule

bind loop_index_unit lbx_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LOOP(NUM_LOOP), .NUM_IDX(NUM_IDX)) u_chk (
  .clk(clk), .rstN(rstN), .cjEn(cjEn), .initEn(initEn), .incEn(incEn),
  .loopSel(loopSel), .idxSel(idxSel), .immVal(immVal), .pcIn(pcIn),
  .targetAddr(targetAddr), .nextPc(nextPc), .ctrl(ctrl),
  .armedVec(u_dp.armedVec), .loopBank(u_dp.loopBank), .idxBank(u_dp.idxBank)
);

// File: tb/sim_loop_index_unit.sv
`timescale 1ns/1ps
module sim_loop_index_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cjEn = 1'b0, initEn = 1'b0, incEn = 1'b0;
  logic [2:0] loopSel = '0, idxSel = '0;
  logic [15:0] loopCount = '0, immVal = '0, pcIn = '0, targetAddr = '0;
  logic [15:0] nextPc, effAddr;

  always #10 clk = ~clk;

  loop_index_unit u0 (
    .clk(clk), .rstN(rstN), .cjEn(cjEn), .initEn(initEn), .incEn(incEn),
    .loopSel(loopSel), .idxSel(idxSel), .loopCount(loopCount), .immVal(immVal),
    .pcIn(pcIn), .targetAddr(targetAddr), .nextPc(nextPc), .effAddr(effAddr)
  );

  typedef struct {
    string       tag;
    logic [15:0] pc;
    logic [15:0] ea;
  } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] mLoop [8];
  bit          mArmed [8];
  logic [15:0] mIdx [8];

  task automatic step(input bit cj, input bit ini, input bit inc,
                      input logic [15:0] pc, input logic [15:0] tgt,
                      input logic [15:0] imm, input logic [15:0] cnt,
                      input logic [2:0] ls, input logic [2:0] is, input string tag);
    exp_t e;
    logic [15:0] v;
    @(negedge clk);
    cjEn = cj; initEn = ini; incEn = inc; pcIn = pc; targetAddr = tgt;
    immVal = imm; loopCount = cnt; loopSel = ls; idxSel = is;
    e.tag = tag;
    e.pc  = pc + 16'd1;
    e.ea  = imm + mIdx[is];
    if (cj) begin
      v = mArmed[ls] ? mLoop[ls] : cnt;
      if (v > 16'd1) begin
        e.pc = tgt; mLoop[ls] = v - 16'd1; mArmed[ls] = 1'b1;
      end else begin
        mArmed[ls] = 1'b0;
      end
    end
    if (ini) mIdx[is] = imm;
    else if (inc) mIdx[is] = mIdx[is] + imm;
    expQ.push_back(e);
  endtask

  task automatic idle(input logic [15:0] pc, input logic [15:0] imm,
                      input logic [2:0] is, input string tag);
    step(0, 0, 0, pc, 16'h0, imm, 16'h0, 3'd0, is, tag);
  endtask

  task automatic cj(input logic [15:0] pc, input logic [15:0] tgt,
                    input logic [15:0] cnt, input logic [2:0] ls, input string tag);
    step(1, 0, 0, pc, tgt, 16'h0, cnt, ls, 3'd0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #8;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (nextPc !== e.pc || effAddr !== e.ea) begin
          errors++;
          $display("FAIL %s: nextPc=%h effAddr=%h expected nextPc=%h effAddr=%h",
                   e.tag, nextPc, effAddr, e.pc, e.ea);
        end
      end
    end
  end

  initial begin : driver
    for (int i = 0; i < 8; i++) begin mLoop[i] = '0; mArmed[i] = 1'b0; mIdx[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: every index counter reads 0 after reset
    for (int i = 0; i < 8; i++) idle(16'h0010 + 16'(i), 16'h0100, 3'(i), "R1");
    // R1: loop counter unarmed, so a count of 1 exits at once
    cj(16'h0020, 16'h0008, 16'd1, 3'd6, "R1");
    // R9, R12
    step(0, 1, 0, 16'h0030, 16'h0, 16'h0010, 16'h0, 3'd0, 3'd2, "R9");
    idle(16'h0031, 16'h0100, 3'd2, "R12");
    // R10
    step(0, 0, 1, 16'h0032, 16'h0, 16'h0004, 16'h0, 3'd0, 3'd2, "R10");
    step(0, 0, 1, 16'h0033, 16'h0, 16'h0004, 16'h0, 3'd0, 3'd2, "R10");
    idle(16'h0034, 16'h0000, 3'd2, "R10");
    // R10 wrap modulo 2^16
    step(0, 1, 0, 16'h0035, 16'h0, 16'hFFF0, 16'h0, 3'd0, 3'd5, "R10");
    step(0, 0, 1, 16'h0036, 16'h0, 16'h0020, 16'h0, 3'd0, 3'd5, "R10");
    idle(16'h0037, 16'h0000, 3'd5, "R10");
    // R12 wrap of effective address
    idle(16'h0038, 16'hFFF8, 3'd5, "R12");
    // R11: init wins over increment
    step(0, 1, 1, 16'h0039, 16'h0, 16'h0777, 16'h0, 3'd0, 3'd3, "R11");
    idle(16'h003A, 16'h0000, 3'd3, "R11");
    // R3, R4, R5: trip count 4 on loop counter 1
    cj(16'h0040, 16'h0030, 16'd4, 3'd1, "R3");
    idle(16'h0030, 16'h0, 3'd0, "R2");
    cj(16'h0040, 16'h0030, 16'd9, 3'd1, "R4");
    cj(16'h0040, 16'h0030, 16'd9, 3'd1, "R4");
    cj(16'h0040, 16'h0030, 16'd9, 3'd1, "R5");
    // R6
    cj(16'h0050, 16'h0045, 16'd0, 3'd0, "R6");
    cj(16'h0051, 16'h0045, 16'd1, 3'd0, "R6");
    // R7: re-entry on counter 1 with a new count of 3
    cj(16'h0040, 16'h0030, 16'd3, 3'd1, "R7");
    cj(16'h0040, 16'h0030, 16'd3, 3'd1, "R7");
    cj(16'h0040, 16'h0030, 16'd3, 3'd1, "R7");
    // R8: two loops interleaved
    cj(16'h0060, 16'h0058, 16'd5, 3'd3, "R8");
    cj(16'h0070, 16'h0068, 16'd2, 3'd4, "R8");
    cj(16'h0070, 16'h0068, 16'd2, 3'd4, "R8");
    cj(16'h0060, 16'h0058, 16'd5, 3'd3, "R8");
    idle(16'h0061, 16'h0, 3'd0, "R2");
    cj(16'h0060, 16'h0058, 16'd5, 3'd3, "R8");
    cj(16'h0060, 16'h0058, 16'd5, 3'd3, "R8");
    // R13: count-jump with an index increment in the same cycle
    step(0, 1, 0, 16'h0080, 16'h0, 16'h0200, 16'h0, 3'd0, 3'd7, "R13");
    step(1, 0, 1, 16'h0090, 16'h0081, 16'h0010, 16'd3, 3'd2, 3'd7, "R13");
    step(1, 0, 1, 16'h0090, 16'h0081, 16'h0010, 16'd3, 3'd2, 3'd7, "R13");
    step(1, 1, 1, 16'h0090, 16'h0081, 16'h0040, 16'd3, 3'd2, 3'd7, "R13");
    idle(16'h0091, 16'h0000, 3'd7, "R13");
    // R2: program counter wrap
    idle(16'hFFFF, 16'h0, 3'd0, "R2");
    @(negedge clk);
    cjEn = 0; initEn = 0; incEn = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule